// File: doc/BRIEF.md
# Power-Good Window Monitor with Delay

This block decides when a regulated supply may be declared good. Each digitized sample of the output voltage arrives with a valid strobe and is compared against a tolerance window built around a target code. The window is asymmetric, and its high and low margins are held as fractions of the target in steps of 1/256. The power-good flag rises only after the sample has been inside the window with no fault flagged for a programmable qualification delay. The delay is counted in microsecond ticks taken from a prescaler on the system clock.

The flag falls without any delay as soon as a sample lands outside the window or the fault input is raised. Any interruption during the qualification delay throws away the time already accumulated. The two margins and the delay sit in a small write-only register port. After reset they hold defaults of +15 % / −10 % and 1000 ticks (1 ms).

Top module: `pgmon_top`

## Requirements
- R1: `pg` is high only while the last valid sample was inside the window and `fault` is low. Raising `fault` drives `pg` low on the next clock edge. Releasing it starts a new qualification delay.
- R2: The window is `[target − floor(target·under/256), target + floor(target·over/256)]`, and both ends are inclusive. With target 1000 and the default margins, 903 and 1148 are inside and 902 and 1149 are outside.
- R3: A write with `cfg_we` high at `cfg_addr` 0 loads the over margin from `cfg_wdata[7:0]`. Address 1 loads the under margin the same way. The new window applies to samples taken from the second clock after the write.
- R4: After reset the margins are 38/256 over and 25/256 under, and the delay is 1000 ticks.
- R5: A write at `cfg_addr` 2 loads the delay in ticks from `cfg_wdata[15:0]`. If a qualifying sample is registered at edge k, `pg` rises at edge k + CLKS_PER_TICK·D + 1. A delay of 0 raises `pg` at edge k+1.
- R6: A sample outside the window that is registered at edge k drives `pg` low at edge k+1.
- R7: If qualification is broken before `pg` rises, the tick count restarts from zero. The next rise needs the full delay again.
- R8: `pg` stays low while the qualification delay runs.
- R9: While `smp_valid` is low, `smp_code` is ignored and `pg` keeps its value.
- R10: While reset is active and right after it, `pg` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_code | input | 12 | Digitized output voltage |
| target_code | input | 12 | Target voltage code |
| fault | input | 1 | Active-high fault flag |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register select: 0 over margin, 1 under margin, 2 delay |
| cfg_wdata | input | 16 | Register write data |
| pg | output | 1 | Power-good flag |

## Verification
The bench probes both window edges one code inside and one code outside. A design that gets the rounding or the inclusive ends wrong flips one of those four results. Rise times are checked to the exact edge for the default delay, a short delay and a zero delay. An off-by-one counter or a prescaler that ignores the setting shows up a cycle early or late. A qualification run broken part-way through must not rise early, which exposes a counter that does not restart. Fault assertion and release, a sample that arrives without its strobe, and a zero-width window cover the remaining qualifier paths.

// File: rtl/pgmon_pkg.sv
package pgmon_pkg;

  typedef enum logic [1:0] {
    CFG_OVER  = 2'd0,
    CFG_UNDER = 2'd1,
    CFG_DELAY = 2'd2,
    CFG_RSVD  = 2'd3
  } cfg_addr_e;

  localparam int FRAC_BITS = 8;

  // percent -> fraction in 1/2^FRAC_BITS steps, rounded down
  function automatic int pct_to_frac(input int pct);
    return (pct * (1 << FRAC_BITS)) / 100;
  endfunction

endpackage

// File: rtl/pgmon_cfg.sv
module pgmon_cfg
  import pgmon_pkg::*;
#(
  parameter int PCT_W     = 8,
  parameter int DLY_W     = 16,
  parameter int DATA_W    = 16,
  parameter int OVER_DEF  = 38,
  parameter int UNDER_DEF = 25,
  parameter int DLY_DEF   = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [PCT_W-1:0]  over_q,
  output logic [PCT_W-1:0]  under_q,
  output logic [DLY_W-1:0]  dly_q
);

  cfg_addr_e          sel;
  logic               over_en, under_en, dly_en;
  logic [PCT_W-1:0]   over_d, under_d;
  logic [DLY_W-1:0]   dly_d;

  always_comb begin
    sel      = cfg_addr_e'(cfg_addr);
    over_en  = cfg_we && (sel == CFG_OVER);
    under_en = cfg_we && (sel == CFG_UNDER);
    dly_en   = cfg_we && (sel == CFG_DELAY);
    over_d   = cfg_wdata[PCT_W-1:0];
    under_d  = cfg_wdata[PCT_W-1:0];
    dly_d    = cfg_wdata[DLY_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      over_q  <= PCT_W'(OVER_DEF);
      under_q <= PCT_W'(UNDER_DEF);
      dly_q   <= DLY_W'(DLY_DEF);
    end else begin
      if (over_en)  over_q  <= over_d;
      if (under_en) under_q <= under_d;
      if (dly_en)   dly_q   <= dly_d;
    end
  end

  // R5: a delay write lands in the register on the next edge
  p_delay_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 2'd2) |=> (dly_q == $past(cfg_wdata[DLY_W-1:0])));

  // R3: writes to other addresses leave the margins alone
  p_margin_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_addr == 2'd0) |=> $stable(over_q));

endmodule

// File: rtl/pgmon_window.sv
module pgmon_window #(
  parameter int W     = 12,
  parameter int PCT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     target_code,
  input  logic [PCT_W-1:0] over_frac,
  input  logic [PCT_W-1:0] under_frac,
  input  logic             smp_valid,
  input  logic [W-1:0]     smp_code,
  output logic             in_win_q
);

  localparam int PROD_W = W + PCT_W;

  logic [PROD_W-1:0] up_prod, dn_prod;
  logic [W-1:0]      up_part, dn_part;
  logic [W:0]        hi_d, hi_q;
  logic [W-1:0]      lo_d, lo_q;
  logic              in_win_d;
  logic              win_en;

  // bound arithmetic: next-state
  always_comb begin
    up_prod = {{PCT_W{1'b0}}, target_code} * {{W{1'b0}}, over_frac};
    dn_prod = {{PCT_W{1'b0}}, target_code} * {{W{1'b0}}, under_frac};
    up_part = up_prod[PROD_W-1:PCT_W];
    dn_part = dn_prod[PROD_W-1:PCT_W];
    hi_d    = {1'b0, target_code} + {1'b0, up_part};
    lo_d    = target_code - dn_part;
  end

  // comparison: next-state
  always_comb begin
    win_en   = smp_valid;
    in_win_d = ({1'b0, smp_code} <= hi_q) && (smp_code >= lo_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      in_win_q <= 1'b0;
    else if (win_en) in_win_q <= in_win_d;
  end

  // R2: the upper bound never sits below the lower bound
  p_bound_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hi_q >= {1'b0, lo_q});

  // R9: the window verdict ignores samples without a strobe
  p_no_strobe_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(in_win_q));

endmodule

// File: rtl/pgmon_qual.sv
module pgmon_qual #(
  parameter int DLY_W         = 16,
  parameter int CLKS_PER_TICK = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_win,
  input  logic             fault,
  input  logic [DLY_W-1:0] dly_ticks,
  output logic             pg
);

  localparam int PRE_W = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_TICK - 1);

  logic             qual_ok;
  logic             tick;
  logic             reached;
  logic [PRE_W-1:0] pre_d, pre_q;
  logic [DLY_W-1:0] cnt_d, cnt_q;
  logic             pg_d, pg_q;
  logic             cnt_en;

  always_comb begin
    qual_ok = in_win && !fault;
    tick    = (pre_q == PRE_LAST);
    reached = (cnt_q >= dly_ticks);
    cnt_en  = qual_ok && !pg_q && !reached && tick;
  end

  always_comb begin
    pre_d = pre_q;
    cnt_d = cnt_q;
    pg_d  = pg_q;
    if (!qual_ok) begin
      pre_d = '0;
      cnt_d = '0;
      pg_d  = 1'b0;
    end else if (!pg_q) begin
      if (reached) begin
        pg_d  = 1'b1;
        pre_d = '0;
      end else if (cnt_en) begin
        pre_d = '0;
        cnt_d = cnt_q + 1'b1;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
      pg_q  <= 1'b0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
      pg_q  <= pg_d;
    end
  end

  assign pg = pg_q;

  // R1: pg high only after a cycle with the qualifier met
  p_pg_needs_ok_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pg_q |-> $past(qual_ok));

  // R6: losing the qualifier clears pg on the next edge
  p_fast_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !qual_ok |=> !pg_q);

  // R7: losing the qualifier clears the tick count
  p_count_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !qual_ok |=> (cnt_q == '0));

  // R8: pg rises only once the tick count has reached the delay
  p_rise_after_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_q) |-> $past(cnt_q >= dly_ticks));

endmodule

// File: rtl/pgmon_top.sv
module pgmon_top
  import pgmon_pkg::*;
#(
  parameter int W             = 12,
  parameter int PCT_W         = FRAC_BITS,
  parameter int DLY_W         = 16,
  parameter int DATA_W        = 16,
  parameter int CLKS_PER_TICK = 100,
  parameter int DLY_DEF       = 1000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [W-1:0]      smp_code,
  input  logic [W-1:0]      target_code,
  input  logic              fault,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              pg
);

  localparam int OVER_DEF  = pct_to_frac(15);
  localparam int UNDER_DEF = pct_to_frac(10);

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n_int;
  logic [PCT_W-1:0]       over_frac, under_frac;
  logic [DLY_W-1:0]       dly_ticks;
  logic                   in_win;

  // asynchronous assert, synchronous release
  generate
    if (SYNC_STAGES > 1) begin : g_sync_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= '0;
        else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
      end
    end else begin : g_sync_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= '0;
        else        rst_sync_q <= 1'b1;
      end
    end
  endgenerate

  assign rst_n_int = rst_sync_q[SYNC_STAGES-1];

  pgmon_cfg #(
    .PCT_W(PCT_W), .DLY_W(DLY_W), .DATA_W(DATA_W),
    .OVER_DEF(OVER_DEF), .UNDER_DEF(UNDER_DEF), .DLY_DEF(DLY_DEF)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n_int),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .over_q(over_frac), .under_q(under_frac), .dly_q(dly_ticks)
  );

  pgmon_window #(.W(W), .PCT_W(PCT_W)) u_window (
    .clk(clk), .rst_n(rst_n_int),
    .target_code(target_code), .over_frac(over_frac), .under_frac(under_frac),
    .smp_valid(smp_valid), .smp_code(smp_code), .in_win_q(in_win)
  );

  pgmon_qual #(.DLY_W(DLY_W), .CLKS_PER_TICK(CLKS_PER_TICK)) u_qual (
    .clk(clk), .rst_n(rst_n_int),
    .in_win(in_win), .fault(fault), .dly_ticks(dly_ticks), .pg(pg)
  );

  // R10: pg is low whenever the internal reset is held
  p_reset_low_r10: assert property (@(posedge clk) !rst_n_int |-> !pg);

endmodule

// File: tb/pgmon_top_bench.sv
module pgmon_top_bench;

  localparam int P   = 4;
  localparam int DEF = 1000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_valid;
  logic [11:0] smp_code;
  logic [11:0] target_code;
  logic        fault;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        pg;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    int    at;
    bit    val;
    string req;
  } sb_item_t;

  sb_item_t sb_q[$];
  sb_item_t item;

  pgmon_top #(.CLKS_PER_TICK(P), .DLY_DEF(DEF)) u_pgmon_top (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_code(smp_code),
    .target_code(target_code), .fault(fault), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .pg(pg)
  );

  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare pg against queued expectations at the falling edge
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
      item = sb_q.pop_front();
      checks++;
      if (item.at < cyc || pg !== item.val) begin
        failures++;
        $display("FAIL %s cyc=%0d pg actual=%b expected=%b (due %0d)",
                 item.req, cyc, pg, item.val, item.at);
      end
    end
  end

  task automatic push(input int at, input bit val, input string req);
    sb_item_t it;
    it.at = at; it.val = val; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic drain();
    wait (sb_q.size() == 0);
    @(negedge clk);
  endtask

  // drive one strobed sample at the falling edge of cycle c
  task automatic send(input logic [11:0] code,
                      input int oa, input bit va,
                      input int ob, input bit vb, input string req);
    @(negedge clk);
    push(cyc + oa, va, req);
    push(cyc + ob, vb, req);
    smp_code  = code;
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    drain();
  endtask

  task automatic set_fault(input bit v, input int oa, input bit va,
                           input int ob, input bit vb, input string req);
    @(negedge clk);
    push(cyc + oa, va, req);
    push(cyc + ob, vb, req);
    fault = v;
    drain();
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; smp_valid = 1'b0; smp_code = '0; target_code = 12'd1000;
    fault = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (4) @(negedge clk);
    checks++;
    if (pg !== 1'b0) begin
      failures++;
      $display("FAIL R10 pg in reset actual=%b expected=0", pg);
    end
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    checks++;
    if (pg !== 1'b0) begin
      failures++;
      $display("FAIL R10 pg after reset actual=%b expected=0", pg);
    end

    // R4/R8: default 1000-tick delay, rise exactly on time
    send(12'd1000, 1 + P*DEF, 1'b0, 2 + P*DEF, 1'b1, "R4");

    // R5: program a 5-tick delay
    cfg_write(2'd2, 16'd5);

    // R2: upper edge inclusive, one above outside (R6 fast drop)
    send(12'd1148, 2, 1'b1, 3, 1'b1, "R2");
    send(12'd1149, 1, 1'b1, 2, 1'b0, "R6");
    send(12'd1148, 1 + P*5, 1'b0, 2 + P*5, 1'b1, "R5");

    // R2: lower edge
    send(12'd902, 1, 1'b1, 2, 1'b0, "R2");
    send(12'd903, 1 + P*5, 1'b0, 2 + P*5, 1'b1, "R2");

    // R1: fault drops pg at once, release restarts the delay
    set_fault(1'b1, 1, 1'b0, 5, 1'b0, "R1");
    set_fault(1'b0, P*5, 1'b0, 1 + P*5, 1'b1, "R1");

    // R7: broken qualification restarts the count
    send(12'd1149, 2, 1'b0, 3, 1'b0, "R7");
    send(12'd1000, 2, 1'b0, 10, 1'b0, "R7");
    send(12'd1149, 2, 1'b0, 5, 1'b0, "R7");
    send(12'd1000, 1 + P*5, 1'b0, 2 + P*5, 1'b1, "R7");

    // R3: zero margins, only the target itself qualifies
    cfg_write(2'd0, 16'd0);
    cfg_write(2'd1, 16'd0);
    send(12'd1001, 1, 1'b1, 2, 1'b0, "R3");
    send(12'd999, 2, 1'b0, 2 + P*5, 1'b0, "R3");
    send(12'd1000, 1 + P*5, 1'b0, 2 + P*5, 1'b1, "R3");

    // R5: zero delay
    cfg_write(2'd2, 16'd0);
    send(12'd1100, 2, 1'b0, 3, 1'b0, "R5");
    send(12'd1000, 1, 1'b0, 2, 1'b1, "R5");

    // R9: out-of-window code without strobe is ignored
    @(negedge clk);
    push(cyc + 2, 1'b1, "R9");
    push(cyc + 6, 1'b1, "R9");
    smp_code = 12'd0;
    drain();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired at cyc=%0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule